// File: doc/BRIEF.md
# Lane-Partitioned Byte Shuffle Unit

This block is a one-stage datapath that rearranges the bytes of a 512-bit data operand. The rearrangement is steered by a 512-bit control operand that holds one control byte for each result byte. Each control byte does one of two things:

- It names a source byte inside its own 16-byte lane, or inside the lowest 8 bytes in the narrow mode.
- If its top bit is set, it forces the result byte to zero.

The active vector length can be set to 64, 128, 256 or 512 bits. Result bytes above that length are cleared. A per-byte write mask can be applied on top of the shuffle. A byte whose mask bit is 0 either keeps the old destination byte (merge) or is cleared (zeroing).

A legacy 128-bit mode shuffles the old destination value in place. In that mode the bytes above the lowest 16 are passed through unchanged.

The result is registered. It appears one clock after a valid strobe and then holds until the next strobe.

Top module: `bsu_shuffle_unit`

## Requirements
- R1: For any result byte being shuffled, a control byte with bit 7 set gives a result byte of 0x00, whatever its low bits are.
- R2: When the length select is 1, 2 or 3, result byte d takes source byte 16*(d/16) + (control bits 3:0). No byte is ever taken from another 16-byte lane.
- R3: The length select `vl_sel` encodes the active length as 0 = 8 bytes, 1 = 16, 2 = 32 and 3 = 64. Outside legacy mode, every result byte at or above the active length is 0x00.
- R4: With `vl_sel` = 0 (narrow mode), control bits 2:0 pick one of source bytes 0..7. Taking bytes from highest to lowest, control 07 07 FF 80 01 00 00 00 on data 04 01 07 03 02 02 FF 01 gives 04 04 00 00 FF 01 01 01.
- R5: When `mask_en` is 1 and `mask_zero` is 0, an active byte whose `byte_mask` bit is 0 keeps the matching byte of `old_dst`.
- R6: When `mask_en` is 1 and `mask_zero` is 1, an active byte whose `byte_mask` bit is 0 becomes 0x00.
- R7: When `mask_en` is 0, every active byte carries the shuffle result.
- R8: When `legacy_mode` is 1, `vl_sel` is ignored and the active length is 16 bytes. The data bytes come from `old_dst`, and result bytes 16..63 equal `old_dst` bytes 16..63.
- R9: In legacy mode and in narrow mode, `byte_mask`, `mask_en` and `mask_zero` have no effect.
- R10: `out_data` and `out_valid` update one clock after `in_valid` is sampled high. `out_valid` equals `in_valid` delayed by one clock, and `out_data` holds its value while `in_valid` is low.
- R11: While `rst_n` is low, `out_data` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid; the result is loaded on this edge |
| src_data | input | 512 | Data operand to be shuffled |
| src_ctrl | input | 512 | One control byte per result byte |
| old_dst | input | 512 | Previous destination value, used for merge and for legacy mode |
| byte_mask | input | 64 | Per-byte write mask |
| vl_sel | input | 2 | Active length select |
| mask_en | input | 1 | Enables the per-byte mask |
| mask_zero | input | 1 | Masked-off bytes are zeroed (1) or merged (0) |
| legacy_mode | input | 1 | In-place 128-bit shuffle that keeps the upper destination bytes |
| out_valid | output | 1 | Result valid |
| out_data | output | 512 | Registered result |

## Verification
The only state in the block is the result register and the valid flag. A wrong value in either shows at the ports on the very next clock.

A mis-steered index or a lane boundary off by one corrupts particular bytes rather than the whole word. The stimulus therefore mixes a different index, zero-force bit and mask bit into every byte, so that a single wrong byte changes the compared 512-bit word.

A register that fails to hold shows up as changed output on the first idle cycle after a result. The bench checks that cycle directly.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic [1:0] {
    VL_NARROW = 2'd0,
    VL_ONE    = 2'd1,
    VL_TWO    = 2'd2,
    VL_FOUR   = 2'd3
  } vl_e;
endpackage

// File: rtl/bsu_lane.sv
module bsu_lane #(
  parameter int LANE_BYTES = 16,
  parameter int NARROW_W   = 3,
  localparam int IDX_W     = $clog2(LANE_BYTES),
  localparam int LW        = LANE_BYTES * 8
) (
  input  logic [LW-1:0] lane_data,
  input  logic [LW-1:0] lane_ctrl,
  input  logic          narrow,
  output logic [LW-1:0] lane_res
);
  for (genvar b = 0; b < LANE_BYTES; b++) begin : g_byte
    logic [7:0]       cbyte;
    logic [IDX_W-1:0] idx;
    assign cbyte = lane_ctrl[b*8 +: 8];
    // narrow mode uses fewer index bits; upper index bits forced to zero
    assign idx   = narrow ? IDX_W'(cbyte[NARROW_W-1:0]) : cbyte[IDX_W-1:0];
    assign lane_res[b*8 +: 8] = cbyte[7] ? 8'h00 : lane_data[idx*8 +: 8];
  end
endmodule

// File: rtl/bsu_merge.sv
module bsu_merge #(
  parameter int NBYTES = 64,
  localparam int ACT_W = $clog2(NBYTES) + 1,
  localparam int DW    = NBYTES * 8
) (
  input  logic [DW-1:0]     shuf,
  input  logic [DW-1:0]     old,
  input  logic [NBYTES-1:0] mask,
  input  logic [ACT_W-1:0]  act_bytes,
  input  logic              mask_use,
  input  logic              mask_zero,
  input  logic              keep_upper,
  output logic [DW-1:0]     merged
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic active, enabled;
    assign active  = ACT_W'(i) < act_bytes;
    assign enabled = !mask_use || mask[i];
    always_comb begin
      if (!active)       merged[i*8 +: 8] = keep_upper ? old[i*8 +: 8] : 8'h00;
      else if (enabled)  merged[i*8 +: 8] = shuf[i*8 +: 8];
      else if (mask_zero) merged[i*8 +: 8] = 8'h00;
      else               merged[i*8 +: 8] = old[i*8 +: 8];
    end
  end
endmodule

// File: rtl/bsu_shuffle_unit.sv
module bsu_shuffle_unit #(
  parameter int NBYTES       = 64,
  parameter int LANE_BYTES   = 16,
  parameter int NARROW_BYTES = 8,
  parameter int LEGACY_BYTES = 16,
  localparam int DW          = NBYTES * 8,
  localparam int NLANES      = NBYTES / LANE_BYTES,
  localparam int LW          = LANE_BYTES * 8,
  localparam int ACT_W       = $clog2(NBYTES) + 1,
  localparam int NARROW_W    = $clog2(NARROW_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DW-1:0]     src_data,
  input  logic [DW-1:0]     src_ctrl,
  input  logic [DW-1:0]     old_dst,
  input  logic [NBYTES-1:0] byte_mask,
  input  logic [1:0]        vl_sel,
  input  logic              mask_en,
  input  logic              mask_zero,
  input  logic              legacy_mode,
  output logic              out_valid,
  output logic [DW-1:0]     out_data
);
  import bsu_pkg::*;

  logic              narrow;
  logic [DW-1:0]     data_sel, shuf, merged, res_d;
  logic [ACT_W-1:0]  act_bytes;
  logic              mask_use, vld_d;

  assign narrow   = !legacy_mode && (vl_e'(vl_sel) == VL_NARROW);
  assign data_sel = legacy_mode ? old_dst : src_data;
  assign mask_use = mask_en && !legacy_mode && !narrow;

  always_comb begin
    if (legacy_mode) act_bytes = ACT_W'(LEGACY_BYTES);
    else begin
      unique case (vl_e'(vl_sel))
        VL_NARROW: act_bytes = ACT_W'(NARROW_BYTES);
        VL_ONE:    act_bytes = ACT_W'(LANE_BYTES);
        VL_TWO:    act_bytes = ACT_W'(2 * LANE_BYTES);
        default:   act_bytes = ACT_W'(NBYTES);
      endcase
    end
  end

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    bsu_lane #(.LANE_BYTES(LANE_BYTES), .NARROW_W(NARROW_W)) u_lane (
      .lane_data (data_sel[l*LW +: LW]),
      .lane_ctrl (src_ctrl[l*LW +: LW]),
      .narrow    (narrow),
      .lane_res  (shuf[l*LW +: LW])
    );
  end

  bsu_merge #(.NBYTES(NBYTES)) u_merge (
    .shuf       (shuf),
    .old        (old_dst),
    .mask       (byte_mask),
    .act_bytes  (act_bytes),
    .mask_use   (mask_use),
    .mask_zero  (mask_zero),
    .keep_upper (legacy_mode),
    .merged     (merged)
  );

  // next state: load on strobe, otherwise hold
  always_comb begin
    vld_d = in_valid;
    res_d = in_valid ? merged : out_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= vld_d;
      out_data  <= res_d;
    end
  end
endmodule

// File: rtl/bsu_shuffle_unit_chk.sv
module bsu_shuffle_unit_chk #(
  parameter int NBYTES = 64,
  localparam int DW    = NBYTES * 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DW-1:0]     src_ctrl,
  input logic [DW-1:0]     old_dst,
  input logic [NBYTES-1:0] byte_mask,
  input logic [1:0]        vl_sel,
  input logic              mask_en,
  input logic              mask_zero,
  input logic              legacy_mode,
  input logic              out_valid,
  input logic [DW-1:0]     out_data
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R10
  a_r10_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid)));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  // R1
  a_r1_zero_force: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy_mode && vl_sel == 2'd3 && !mask_en && src_ctrl[7])
      |=> (out_data[7:0] == 8'h00));
  // R3
  a_r3_above_len: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy_mode && vl_sel == 2'd1) |=> (out_data[DW-1:128] == '0));
  // R8
  a_r8_legacy_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legacy_mode) |=> (out_data[DW-1:128] == $past(old_dst[DW-1:128])));
  // R5
  a_r5_merge: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_en && !mask_zero && !legacy_mode && vl_sel != 2'd0 && !byte_mask[0])
      |=> (out_data[7:0] == $past(old_dst[7:0])));
  // R6
  a_r6_zeroing: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_en && mask_zero && !legacy_mode && vl_sel != 2'd0 && !byte_mask[0])
      |=> (out_data[7:0] == 8'h00));
endmodule

bind bsu_shuffle_unit bsu_shuffle_unit_chk #(.NBYTES(NBYTES)) u_chk (.*);

// File: tb/bsu_shuffle_unit_tb.sv
module bsu_shuffle_unit_tb;
  localparam int NB = 64;
  localparam int DW = NB * 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] src_data, src_ctrl, old_dst, out_data;
  logic [NB-1:0] byte_mask;
  logic [1:0]    vl_sel;
  logic          mask_en, mask_zero, legacy_mode, out_valid;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bsu_shuffle_unit u_dut (.*);

  typedef struct packed {
    logic [1:0] vl;
    logic       me;
    logic       mz;
    logic       leg;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'd3, 1'b0, 1'b0, 1'b0, 8'd1},
    '{2'd2, 1'b0, 1'b0, 1'b0, 8'd2},
    '{2'd1, 1'b0, 1'b0, 1'b0, 8'd3},
    '{2'd0, 1'b0, 1'b0, 1'b0, 8'd4},
    '{2'd3, 1'b1, 1'b0, 1'b0, 8'd5},
    '{2'd3, 1'b1, 1'b1, 1'b0, 8'd6},
    '{2'd2, 1'b1, 1'b0, 1'b0, 8'd7},
    '{2'd1, 1'b0, 1'b0, 1'b1, 8'd8},
    '{2'd2, 1'b1, 1'b1, 1'b1, 8'd9},
    '{2'd0, 1'b1, 1'b1, 1'b0, 8'd10}
  };

  function automatic logic [DW-1:0] ref_model(
      logic [DW-1:0] s, logic [DW-1:0] c, logic [DW-1:0] o, logic [NB-1:0] m,
      logic [1:0] vl, logic me, logic mz, logic leg);
    logic [DW-1:0] r;
    int active = leg ? 16 : (8 << vl);
    bit nar = !leg && vl == 2'd0;
    for (int d = 0; d < NB; d++) begin
      logic [7:0] cb = c[d*8 +: 8];
      bit en = (me && !leg && !nar) ? m[d] : 1'b1;
      int base = nar ? 0 : (d / 16) * 16;
      int idx = nar ? int'(cb[2:0]) : int'(cb[3:0]);
      if (d >= active)  r[d*8 +: 8] = leg ? o[d*8 +: 8] : 8'h00;
      else if (!en)     r[d*8 +: 8] = mz ? 8'h00 : o[d*8 +: 8];
      else if (cb[7])   r[d*8 +: 8] = 8'h00;
      else              r[d*8 +: 8] = leg ? o[(base+idx)*8 +: 8] : s[(base+idx)*8 +: 8];
    end
    return r;
  endfunction

  task automatic check(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic drive(logic [DW-1:0] s, logic [DW-1:0] c, logic [DW-1:0] o,
                       logic [NB-1:0] m, logic [1:0] vl, logic me, logic mz, logic leg);
    @(negedge clk);
    src_data = s; src_ctrl = c; old_dst = o; byte_mask = m;
    vl_sel = vl; mask_en = me; mask_zero = mz; legacy_mode = leg; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] s, c, o, exp, held;
    logic [NB-1:0] m;
    rst_n = 1'b0; in_valid = 1'b0; src_data = '0; src_ctrl = '0; old_dst = '0;
    byte_mask = '0; vl_sel = 2'd0; mask_en = 1'b0; mask_zero = 1'b0; legacy_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset out_data", out_data, '0);
    check("R11 reset out_valid", DW'(out_valid), '0);
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R5 R6 R7 R8 R9
    foreach (VECS[k]) begin
      for (int d = 0; d < NB; d++) begin
        s[d*8 +: 8] = 8'(d * 37 + VECS[k].seed * 11 + 3) ^ VECS[k].seed;
        c[d*8 +: 8] = 8'(d * 53 + VECS[k].seed * 29);
        o[d*8 +: 8] = 8'(d * 91 + VECS[k].seed * 7 + 1);
        m[d] = ((d * 3 + VECS[k].seed) % 5) != 0;
      end
      drive(s, c, o, m, VECS[k].vl, VECS[k].me, VECS[k].mz, VECS[k].leg);
      exp = ref_model(s, c, o, m, VECS[k].vl, VECS[k].me, VECS[k].mz, VECS[k].leg);
      check($sformatf("R1 R2 R3 R5 R6 R7 R8 R9 vector %0d", k), out_data, exp);
      check("R10 out_valid after strobe", DW'(out_valid), DW'(1));
    end

    // R4 narrow-mode worked example
    s = '0; s[63:0] = 64'h04010703_0202FF01;
    c = '0; c[63:0] = 64'h0707FF80_01000000;
    drive(s, c, {DW{1'b1}}, '0, 2'd0, 1'b1, 1'b0, 1'b0);
    check("R4 narrow example", out_data, {448'h0, 64'h04040000_FF010101});

    // R2 lanes stay separate: every index 15
    for (int d = 0; d < NB; d++) begin
      s[d*8 +: 8] = 8'(d);
      c[d*8 +: 8] = 8'h0F;
      exp[d*8 +: 8] = 8'((d / 16) * 16 + 15);
    end
    drive(s, c, '0, '0, 2'd3, 1'b0, 1'b0, 1'b0);
    check("R2 lane-local index", out_data, exp);

    // R1 all control bytes with bit 7 set
    drive(s, {NB{8'h8F}}, {DW{1'b1}}, '0, 2'd3, 1'b0, 1'b0, 1'b0);
    check("R1 zero force", out_data, '0);

    // R10 hold while idle
    drive(s, c, '0, '0, 2'd3, 1'b0, 1'b0, 1'b0);
    held = out_data;
    src_data = ~s;
    @(negedge clk);
    check("R10 hold data", out_data, held);
    check("R10 valid low when idle", DW'(out_valid), '0);

    // R11 reset mid-run
    rst_n = 1'b0;
    #1;
    check("R11 async clear", out_data, '0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule